// File: doc/BRIEF.md
# Buffered-Compare Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a shared up-counter. The counter runs from zero up to a programmable terminal value and then starts again at zero. One compare value sets the length of the period and a second sets where the output falls. The output is high from the start of each period until the counter reaches the second compare value. It is low for the rest of the period.

Software programs the block through a small synchronous register port. Compare values are written into staging copies and are not used straight away. Setting a per-value load-request bit arms the transfer. At the next period boundary the armed staging values move into the working compare registers and the request bits clear themselves. This lets software change period and duty without ever producing a truncated or merged pulse.

A control register starts and stops the counter, holds the counter and its clock divider at zero, and gates the output. A programmable divider sets how many system clocks make one counter step.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After the asynchronous reset, `pwm_out` is low and every readable register (addresses 0 to 7) returns zero.
- R2: The counter steps from 0 up to the working period value P and then returns to 0, so one period lasts P+1 counter steps. At divide-by-1 this is P+1 system clocks.
- R3: With working duty value D, `pwm_out` is high for the first D counter steps of each period and low for the rest. D = 0 keeps the output low, and D greater than P keeps it high for the whole period.
- R4: A write to the staging period (address 2) or staging duty (address 3) leaves the working values and the output waveform unchanged until its load request is set and a period boundary has passed.
- R5: The load-request register (address 4) has two bits. Bit 0 arms the period and bit 1 arms the duty. Writing 1 sets a bit and writing 0 has no effect. A set bit reads back as 1 until its transfer happens at a boundary, and then reads 0.
- R6: While control bit 1 (hold) is set, the counter and the divider stay at zero and `pwm_out` is low. Every armed staging value is transferred during hold, and its request bit then clears.
- R7: Control bit 0 (run) enables counting. While it is clear and hold is clear, the counter value and the `pwm_out` level stay frozen.
- R8: While control bit 3 (output enable) is clear, `pwm_out` is low and the counter keeps running if run is set.
- R9: With divider value N (address 1), the counter advances once every N+1 system clocks. N = 0 passes the system clock unchanged, so each period lasts (P+1)(N+1) clocks and each high phase lasts D(N+1) clocks.
- R10: The read port is combinational. Address 0 returns control, 1 the divider, 2 and 3 the staging period and duty, 4 the pending load requests, 5 the counter, and 6 and 7 the working period and duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data, combinational |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The waveform is measured edge to edge in system clocks for several settings: a period of 19 with duty 9, a shortened period of 10, and a divided clock of 3 with period 5 and duty 2. Each measurement separates the period arithmetic from the duty arithmetic and the divider scaling. The duty extremes 0 and above-period are checked as constant levels over many periods. Staging writes without a load request are shown to leave both the waveform and the working registers unchanged. The hold, freeze and output-off patterns each isolate one control bit, because each is checked through both `pwm_out` and the counter readback.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // control register bit positions (software decodes these)
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_HOLD = 1;
  localparam int CTRL_OUTE = 3;
  localparam int CTRL_W    = 4;

  // load-request bit positions
  localparam int LREQ_PER  = 0;
  localparam int LREQ_DUTY = 1;
  localparam int LREQ_W    = 2;

  typedef enum logic [2:0] {
    A_CTRL     = 3'd0,
    A_DIV      = 3'd1,
    A_PER_STG  = 3'd2,
    A_DUTY_STG = 3'd3,
    A_LREQ     = 3'd4,
    A_COUNT    = 3'd5,
    A_PER_WRK  = 3'd6,
    A_DUTY_WRK = 3'd7
  } reg_addr_e;

  // counter is at the last step of its period
  function automatic logic f_last_step(input int unsigned cnt, input int unsigned per);
    return cnt == per;
  endfunction

  // output level for a counter value and duty value
  function automatic logic f_level(input int unsigned cnt, input int unsigned duty);
    return cnt < duty;
  endfunction

  // divider says a counter step is due
  function automatic logic f_step_due(input int unsigned pre_cnt, input int unsigned div);
    return pre_cnt >= div;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              period_load,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [CNT_W-1:0]  per_stg,
  output logic [CNT_W-1:0]  duty_stg,
  output logic [CNT_W-1:0]  per_wrk,
  output logic [CNT_W-1:0]  duty_wrk,
  output logic [LREQ_W-1:0] lreq_q
);

  logic              wr_ctrl, wr_div, wr_per, wr_duty, wr_lreq;
  logic [LREQ_W-1:0] lreq_set, lreq_done;
  logic              xfer_per, xfer_duty;

  always_comb begin
    wr_ctrl = wr_en && (wr_addr == A_CTRL);
    wr_div  = wr_en && (wr_addr == A_DIV);
    wr_per  = wr_en && (wr_addr == A_PER_STG);
    wr_duty = wr_en && (wr_addr == A_DUTY_STG);
    wr_lreq = wr_en && (wr_addr == A_LREQ);
  end

  assign lreq_set  = wr_lreq ? wr_data[LREQ_W-1:0] : '0;
  assign xfer_per  = period_load && lreq_q[LREQ_PER];
  assign xfer_duty = period_load && lreq_q[LREQ_DUTY];
  assign lreq_done = {xfer_duty, xfer_per};

  // control and divider take effect at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
      if (wr_div)  div_q  <= wr_data[DIV_W-1:0];
    end
  end

  // staging copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_stg  <= '0;
      duty_stg <= '0;
    end else begin
      if (wr_per)  per_stg  <= wr_data;
      if (wr_duty) duty_stg <= wr_data;
    end
  end

  // load requests: a new set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lreq_q <= '0;
    else        lreq_q <= (lreq_q & ~lreq_done) | lreq_set;
  end

  // working compare values move only at a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_wrk  <= '0;
      duty_wrk <= '0;
    end else begin
      if (xfer_per)  per_wrk  <= per_stg;
      if (xfer_duty) duty_wrk <= duty_stg;
    end
  end

  a_r4_per_wrk_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !period_load |=> $stable(per_wrk));
  a_r4_duty_wrk_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !period_load |=> $stable(duty_wrk));
  a_r5_per_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (period_load && lreq_q[LREQ_PER] && !(wr_lreq && wr_data[LREQ_PER])) |=> !lreq_q[LREQ_PER]);
  a_r5_duty_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (period_load && lreq_q[LREQ_DUTY] && !(wr_lreq && wr_data[LREQ_DUTY])) |=> !lreq_q[LREQ_DUTY]);
  a_r6_hold_transfers: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTRL_HOLD] && lreq_q[LREQ_PER]) |=> (per_wrk == $past(per_stg)));

endmodule

// File: rtl/pwm_divider.sv
module pwm_divider
  import pwm_shadow_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_val,
  output logic             step
);

  logic [DIV_W-1:0] pre_cnt;

  assign step = run && !hold && f_step_due(32'(pre_cnt), 32'(div_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_cnt <= '0;
    else if (hold) pre_cnt <= '0;
    else if (run)  pre_cnt <= step ? '0 : pre_cnt + 1'b1;
  end

  a_r9_step_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && div_val != '0) |=> (!step || div_val == '0));
  a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pre_cnt == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = step && f_last_step(32'(cnt), 32'(period));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + 1'b1;
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period);
  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !hold) |=> $stable(cnt));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             out_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_q
);

  logic level;

  assign level = out_en && !hold && f_level(32'(cnt), 32'(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= level;
  end

  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !pwm_q);
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !pwm_q);
  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !pwm_q);
  a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !hold && cnt == '0 && duty != '0) |=> pwm_q);

endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);

  localparam int CTRL_PAD = CNT_W - CTRL_W;
  localparam int DIV_PAD  = CNT_W - DIV_W;
  localparam int LREQ_PAD = CNT_W - LREQ_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  per_stg, duty_stg, per_wrk, duty_wrk, cnt;
  logic [LREQ_W-1:0] lreq_q;
  logic              step, wrap, period_load;
  logic              ctl_run, ctl_hold, ctl_oute;

  assign ctl_run     = ctrl_q[CTRL_RUN];
  assign ctl_hold    = ctrl_q[CTRL_HOLD];
  assign ctl_oute    = ctrl_q[CTRL_OUTE];
  // a boundary is either the end of a period or a held counter
  assign period_load = wrap || ctl_hold;

  pwm_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .period_load(period_load),
    .ctrl_q(ctrl_q), .div_q(div_q),
    .per_stg(per_stg), .duty_stg(duty_stg),
    .per_wrk(per_wrk), .duty_wrk(duty_wrk),
    .lreq_q(lreq_q)
  );

  pwm_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .run(ctl_run), .hold(ctl_hold), .div_val(div_q),
    .step(step)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n),
    .step(step), .hold(ctl_hold), .period(per_wrk),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_channel #(.CNT_W(CNT_W)) u_ch (
    .clk(clk), .rst_n(rst_n),
    .hold(ctl_hold), .out_en(ctl_oute),
    .cnt(cnt), .duty(duty_wrk),
    .pwm_q(pwm_out)
  );

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      A_CTRL:     rd_data = {{CTRL_PAD{1'b0}}, ctrl_q};
      A_DIV:      rd_data = {{DIV_PAD{1'b0}}, div_q};
      A_PER_STG:  rd_data = per_stg;
      A_DUTY_STG: rd_data = duty_stg;
      A_LREQ:     rd_data = {{LREQ_PAD{1'b0}}, lreq_q};
      A_COUNT:    rd_data = cnt;
      A_PER_WRK:  rd_data = per_wrk;
      A_DUTY_WRK: rd_data = duty_wrk;
      default:    rd_data = '0;
    endcase
  end

  a_r7_stopped_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !ctl_hold && $stable(ctrl_q) && $stable(duty_wrk)) |=> $stable(pwm_out));

endmodule

// File: tb/pwm_shadow_gen_bench.sv
module pwm_shadow_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         pwm_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_gen u_pwm_shadow_gen (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_out(pwm_out)
  );

  // expected values restated from the requirements
  function automatic int exp_period(input int per, input int dv);
    return (per + 1) * (dv + 1);
  endfunction
  function automatic int exp_high(input int per, input int duty, input int dv);
    int steps;
    steps = (duty > per) ? per + 1 : duty;
    return steps * (dv + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic wait_lreq_clear(input string req);
    int v = 1;
    for (int i = 0; i < 500 && v != 0; i++) rd(3'd4, v);
    check(req, v, 0);
  endtask

  // high and total length of one full period, in clocks
  task automatic measure(output int hi, output int per);
    logic prev, found;
    prev = 1'b1; found = 1'b0; hi = -1; per = -1;
    for (int i = 0; i < 3000 && !found; i++) begin
      @(negedge clk);
      if (!prev && pwm_out) found = 1'b1;
      prev = pwm_out;
    end
    if (found) begin
      hi = 0; per = 0;
      while (pwm_out && hi < 3000) begin hi++; per++; @(negedge clk); end
      while (!pwm_out && per < 6000) begin per++; @(negedge clk); end
    end
  endtask

  task automatic steady(input string req, input logic lvl);
    int diffs = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwm_out !== lvl) diffs++;
    end
    check(req, diffs, 0);
  endtask

  task automatic t_reset();
    int v;
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 R10 reg %0d after reset", a), v, 0);
    end
  endtask

  task automatic t_basic();
    int hi, per;
    wr(3'd2, 18); wr(3'd3, 9); wr(3'd4, 3);
    rd(3'd4, hi);
    check("R5 requests pending before run", hi, 3);
    wr(3'd0, 9);
    wait_lreq_clear("R5 requests clear after boundary");
    measure(hi, per);
    check("R2 period 18", per, exp_period(18, 0));
    check("R3 duty 9", hi, exp_high(18, 9, 0));
  endtask

  task automatic t_shadow();
    int hi, per, v;
    wr(3'd2, 9);
    repeat (60) @(negedge clk);
    measure(hi, per);
    check("R4 staged period not yet used", per, exp_period(18, 0));
    rd(3'd6, v); check("R4 working period unchanged", v, 18);
    rd(3'd2, v); check("R10 staging period readback", v, 9);
    wr(3'd4, 1);
    wait_lreq_clear("R5 period request clears");
    measure(hi, per);
    check("R2 R4 period 9 after load", per, exp_period(9, 0));
    check("R3 duty 9 of period 9", hi, exp_high(9, 9, 0));
  endtask

  task automatic t_edges();
    wr(3'd3, 0); wr(3'd4, 2);
    wait_lreq_clear("R5 duty request clears");
    repeat (3) @(negedge clk);
    steady("R3 duty 0 stays low", 1'b0);
    wr(3'd3, 12); wr(3'd4, 2);
    wait_lreq_clear("R5 duty request clears");
    repeat (3) @(negedge clk);
    steady("R3 duty above period stays high", 1'b1);
  endtask

  task automatic t_divider();
    int hi, per;
    wr(3'd1, 2); wr(3'd2, 4); wr(3'd3, 2); wr(3'd4, 3);
    wait_lreq_clear("R5 both requests clear");
    measure(hi, per);
    check("R9 divided period", per, exp_period(4, 2));
    check("R9 divided high", hi, exp_high(4, 2, 2));
  endtask

  task automatic t_out_off();
    int c0, c1;
    wr(3'd0, 1);
    repeat (3) @(negedge clk);
    steady("R8 output disabled low", 1'b0);
    rd(3'd5, c0);
    repeat (3) @(negedge clk);
    rd(3'd5, c1);
    total++;
    if (c0 == c1) begin
      bad++;
      $display("FAIL R8 counter stopped: actual=%0d expected!=%0d", c1, c0);
    end
  endtask

  task automatic t_freeze();
    int c0, c1;
    logic l0;
    wr(3'd0, 9);
    repeat (7) @(negedge clk);
    wr(3'd0, 8);
    repeat (2) @(negedge clk);
    l0 = pwm_out;
    rd(3'd5, c0);
    repeat (20) @(negedge clk);
    rd(3'd5, c1);
    check("R7 counter frozen", c1, c0);
    steady("R7 level frozen", l0);
  endtask

  task automatic t_hold();
    int v, hi, per;
    wr(3'd0, 11);
    repeat (2) @(negedge clk);
    rd(3'd5, v); check("R6 counter zero in hold", v, 0);
    check("R6 output low in hold", int'(pwm_out), 0);
    wr(3'd2, 7); wr(3'd4, 1);
    repeat (2) @(negedge clk);
    rd(3'd6, v); check("R6 transfer during hold", v, 7);
    rd(3'd4, v); check("R6 request clear after hold", v, 0);
    wr(3'd1, 0);
    wr(3'd0, 9);
    measure(hi, per);
    check("R6 period after hold", per, exp_period(7, 0));
    check("R6 high after hold", hi, exp_high(7, 2, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_shadow();
    t_edges();
    t_divider();
    t_out_off();
    t_freeze();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule